// File: doc/BRIEF.md
# DMA Controller Register File and Interrupt Aggregator

This block is the register-facing side of a multi-channel DMA controller. Its channel count is set by a parameter to 2 or 8. It decodes a 4 KB window on a simple one-cycle read/write bus. The window holds three areas. Offsets below 0x100 hold the global status, clear, configuration and sync words. Offsets 0x100 to 0x1FF hold a bank of five 32-bit words for each channel. The top 32 bytes hold a read-only identification area.

The transfer engine is a separate block. It reports completions and failures on per-channel one-cycle set inputs, and it reads every channel's register contents from flat output buses. Inside this block, the raw terminal-count and error flags are kept per channel. Their masks are not separate registers: each channel's configuration word supplies them. Three level interrupt lines are driven: terminal-count, error, and the two combined.

Top module: `dmac_regfile`

## Requirements
- R1: In the cycle after a synchronous reset, these all read as zero: every raw flag, both masks, the global configuration and sync words, every channel word, and the read data. All three interrupt lines are low.
- R2: Offsets 0x100–0x1FF address the channel bank. The channel is offset bits 7:5 and the word is offset bits 4:2, with this word order: 0 source address, 1 destination address, 2 list pointer, 3 control, 4 configuration. Each of these five words is fully read/write. Word positions 5–7 read as zero and ignore writes.
- R3: A channel index equal to or above the channel count reads as zero. A write to it changes no channel word.
- R4: A one on `tc_set[c]` or `err_set[c]` sets the matching raw flag at the next clock edge. A set takes priority over a clear of the same bit in the same cycle.
- R5: Global word 2 clears the raw terminal-count flags and global word 4 clears the raw error flags. Each clears exactly the bits written as one.
- R6: A channel's terminal-count mask is bit 15 of its configuration word, and its error mask is bit 14. Global word 1 reads the masked terminal-count flags and word 3 reads the masked error flags. Word 0 reads the OR of words 1 and 3. Word 5 reads the raw terminal-count flags and word 6 reads the raw error flags. Channel c is reported in bit c.
- R7: `irq_tc` is high when any masked terminal-count flag is set, and `irq_err` is high when any masked error flag is set. `irq_any` is the OR of the two. All three are levels that follow the register state with no extra delay.
- R8: Global word 7 reads a bitmap in which bit c is bit 0 of channel c's configuration word.
- R9: Global word 12 (configuration) and word 13 (sync) are 32-bit read/write registers, and they also appear on `glob_cfg_o` and `glob_sync_o`.
- R10: Global words 8–11 read as zero, and writes to them change no state.
- R11: Offsets 0xFE0–0xFFF each return one byte, zero-extended, selected by offset bits 4:2. The bytes in order are: 0x80 (8 channels) or 0x81 (2 channels), then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.
- R12: Read data is captured at the clock edge that samples a read strobe. It holds its value through idle cycles and write cycles. A write takes effect at the edge that samples it.
- R13: The `ch_*_o` buses carry every channel's five words, with channel c in bits 32c+31:32c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tc_set | input | NCH | Per-channel terminal-count set pulses |
| err_set | input | NCH | Per-channel error set pulses |
| ch_src_o | output | 32*NCH | Source address words, all channels |
| ch_dst_o | output | 32*NCH | Destination address words |
| ch_lli_o | output | 32*NCH | List pointer words |
| ch_ctl_o | output | 32*NCH | Control words |
| ch_cfg_o | output | 32*NCH | Configuration words |
| glob_cfg_o | output | 32 | Global configuration word |
| glob_sync_o | output | 32 | Sync word |
| irq_tc | output | 1 | Masked terminal-count interrupt level |
| irq_err | output | 1 | Masked error interrupt level |
| irq_any | output | 1 | OR of both interrupt levels |

## Verification
The bench uses the 2-channel configuration.

The channel-bank sweep writes a distinct value to every channel/word pair of all eight possible indices, then reads all of them back. This separates correct index and word decoding from aliasing, and it shows that the six unimplemented indices and the three spare word slots neither store data nor disturb the real registers.

The interrupt sweep crosses all 16 mask settings with all 16 raw flag patterns. A mixed-up tc/err mask bit, a masking fault, or a wrong status word shows up in at least one combination.

Separate directed cases cover three things: a clear and a set hitting the same bit in one cycle, partial clears, and software-request writes that are expected to leave the raw flags and global words untouched.

// File: rtl/dmac_reg_pkg.sv
package dmac_reg_pkg;

    localparam int DW = 32;
    localparam int AW = 12;

    // global word indices (offset bits 7:2)
    localparam logic [5:0] GW_ANY     = 6'd0;
    localparam logic [5:0] GW_TC      = 6'd1;
    localparam logic [5:0] GW_TC_CLR  = 6'd2;
    localparam logic [5:0] GW_ERR     = 6'd3;
    localparam logic [5:0] GW_ERR_CLR = 6'd4;
    localparam logic [5:0] GW_RAW_TC  = 6'd5;
    localparam logic [5:0] GW_RAW_ERR = 6'd6;
    localparam logic [5:0] GW_ENABLED = 6'd7;
    localparam logic [5:0] GW_CONF    = 6'd12;
    localparam logic [5:0] GW_SYNC    = 6'd13;

    // channel word indices (offset bits 4:2)
    localparam logic [2:0] CW_SRC = 3'd0;
    localparam logic [2:0] CW_DST = 3'd1;
    localparam logic [2:0] CW_LLI = 3'd2;
    localparam logic [2:0] CW_CTL = 3'd3;
    localparam logic [2:0] CW_CFG = 3'd4;

    localparam int CFG_EN_BIT     = 0;
    localparam int CFG_ERRMSK_BIT = 14;
    localparam int CFG_TCMSK_BIT  = 15;

    typedef enum logic [1:0] {
        AREA_GLOBAL,
        AREA_CHAN,
        AREA_ID,
        AREA_NONE
    } area_e;

    typedef struct packed {
        logic [DW-1:0] src;
        logic [DW-1:0] dst;
        logic [DW-1:0] lli;
        logic [DW-1:0] ctl;
        logic [DW-1:0] cfg;
    } chan_regs_t;

    function automatic area_e area_of(input logic [AW-1:0] a);
        if (a[11:8] == 4'h0)       return AREA_GLOBAL;
        else if (a[11:8] == 4'h1)  return AREA_CHAN;
        else if (a[11:5] == 7'h7F) return AREA_ID;
        else                       return AREA_NONE;
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] idx, input logic wide);
        case (idx)
            3'd0:    return wide ? 8'h80 : 8'h81;
            3'd1:    return 8'h10;
            3'd2:    return 8'h04;
            3'd3:    return 8'h0A;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/dmac_chan_bank.sv
module dmac_chan_bank
    import dmac_reg_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [2:0]             idx,
    input  logic [2:0]             cword,
    input  logic [DW-1:0]          wdata,
    output chan_regs_t [NCH-1:0]   regs
);

    localparam logic [3:0] NCH_W = 4'(NCH);

    chan_regs_t [NCH-1:0] bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else if (wr_en) begin
            for (int c = 0; c < NCH; c++) begin
                if (idx == 3'(c)) begin
                    case (cword)
                        CW_SRC:  bank_q[c].src <= wdata;
                        CW_DST:  bank_q[c].dst <= wdata;
                        CW_LLI:  bank_q[c].lli <= wdata;
                        CW_CTL:  bank_q[c].ctl <= wdata;
                        CW_CFG:  bank_q[c].cfg <= wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    assign regs = bank_q;

    // R3: writes to an unimplemented channel leave the whole bank unchanged
    a_r3_bad_index_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ({1'b0, idx} >= NCH_W)) |=> $stable(bank_q));

    // R2: a spare word slot never changes the bank
    a_r2_spare_word_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (cword > CW_CFG)) |=> $stable(bank_q));

endmodule

// File: rtl/dmac_irq_agg.sv
module dmac_irq_agg #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] tc_set,
    input  logic [NCH-1:0] err_set,
    input  logic           tc_clr_en,
    input  logic           err_clr_en,
    input  logic [NCH-1:0] clr_val,
    input  logic [NCH-1:0] tc_mask,
    input  logic [NCH-1:0] err_mask,
    output logic [NCH-1:0] tc_raw,
    output logic [NCH-1:0] err_raw,
    output logic [NCH-1:0] tc_masked,
    output logic [NCH-1:0] err_masked,
    output logic           irq_tc,
    output logic           irq_err,
    output logic           irq_any
);

    logic [NCH-1:0] tc_clr_bits;
    logic [NCH-1:0] err_clr_bits;

    assign tc_clr_bits  = tc_clr_en  ? clr_val : '0;
    assign err_clr_bits = err_clr_en ? clr_val : '0;

    // set wins over a clear of the same bit in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            tc_raw  <= '0;
            err_raw <= '0;
        end else begin
            tc_raw  <= (tc_raw  & ~tc_clr_bits)  | tc_set;
            err_raw <= (err_raw & ~err_clr_bits) | err_set;
        end
    end

    assign tc_masked  = tc_raw  & tc_mask;
    assign err_masked = err_raw & err_mask;
    assign irq_tc     = |tc_masked;
    assign irq_err    = |err_masked;
    assign irq_any    = irq_tc | irq_err;

    // R1: reset empties both flag sets
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (tc_raw == '0 && err_raw == '0));

    // R4: a set pulse always lands, even against a clear
    a_r4_set_lands: assert property (@(posedge clk) disable iff (rst)
        (|tc_set) |=> ((tc_raw & $past(tc_set)) == $past(tc_set)));

    // R5: cleared bits without a competing set are gone next cycle
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (rst)
        err_clr_en |=> ((err_raw & $past(clr_val & ~err_set)) == '0));

    // R4: no raw flag appears without its set pulse
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((tc_raw & ~$past(tc_raw) & ~$past(tc_set)) == '0));

endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
    import dmac_reg_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCH-1:0]    tc_set,
    input  logic [NCH-1:0]    err_set,
    output logic [32*NCH-1:0] ch_src_o,
    output logic [32*NCH-1:0] ch_dst_o,
    output logic [32*NCH-1:0] ch_lli_o,
    output logic [32*NCH-1:0] ch_ctl_o,
    output logic [32*NCH-1:0] ch_cfg_o,
    output logic [31:0]       glob_cfg_o,
    output logic [31:0]       glob_sync_o,
    output logic              irq_tc,
    output logic              irq_err,
    output logic              irq_any
);

    localparam logic [3:0] NCH_W = 4'(NCH);
    localparam logic       WIDE  = (NCH == 8);

    area_e                area;
    logic [5:0]           gword;
    logic [2:0]           ch_idx;
    logic [2:0]           cword;
    logic                 wr_acc;
    logic                 rd_acc;
    logic                 addr_lo_unused;

    chan_regs_t [NCH-1:0] bank;
    logic [NCH-1:0]       tc_mask, err_mask, ena_map;
    logic [NCH-1:0]       tc_raw, err_raw, tc_masked, err_masked;
    logic [31:0]          conf_q, sync_q;
    logic [31:0]          rd_mux;
    chan_regs_t           sel_ch;

    assign area           = area_of(bus_addr);
    assign gword          = bus_addr[7:2];
    assign ch_idx         = bus_addr[7:5];
    assign cword          = bus_addr[4:2];
    assign wr_acc         = bus_sel && bus_wr;
    assign rd_acc         = bus_sel && !bus_wr;
    assign addr_lo_unused = ^bus_addr[1:0];

    dmac_chan_bank #(.NCH(NCH)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_acc && area == AREA_CHAN),
        .idx   (ch_idx),
        .cword (cword),
        .wdata (bus_wdata),
        .regs  (bank)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign tc_mask[c]            = bank[c].cfg[CFG_TCMSK_BIT];
        assign err_mask[c]           = bank[c].cfg[CFG_ERRMSK_BIT];
        assign ena_map[c]            = bank[c].cfg[CFG_EN_BIT];
        assign ch_src_o[32*c +: 32]  = bank[c].src;
        assign ch_dst_o[32*c +: 32]  = bank[c].dst;
        assign ch_lli_o[32*c +: 32]  = bank[c].lli;
        assign ch_ctl_o[32*c +: 32]  = bank[c].ctl;
        assign ch_cfg_o[32*c +: 32]  = bank[c].cfg;
    end

    dmac_irq_agg #(.NCH(NCH)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .tc_set     (tc_set),
        .err_set    (err_set),
        .tc_clr_en  (wr_acc && area == AREA_GLOBAL && gword == GW_TC_CLR),
        .err_clr_en (wr_acc && area == AREA_GLOBAL && gword == GW_ERR_CLR),
        .clr_val    (bus_wdata[NCH-1:0]),
        .tc_mask    (tc_mask),
        .err_mask   (err_mask),
        .tc_raw     (tc_raw),
        .err_raw    (err_raw),
        .tc_masked  (tc_masked),
        .err_masked (err_masked),
        .irq_tc     (irq_tc),
        .irq_err    (irq_err),
        .irq_any    (irq_any)
    );

    // global configuration and sync words
    always_ff @(posedge clk) begin
        if (rst) begin
            conf_q <= '0;
            sync_q <= '0;
        end else if (wr_acc && area == AREA_GLOBAL) begin
            if (gword == GW_CONF) conf_q <= bus_wdata;
            if (gword == GW_SYNC) sync_q <= bus_wdata;
        end
    end

    assign glob_cfg_o  = conf_q;
    assign glob_sync_o = sync_q;

    // read selection
    always_comb begin
        sel_ch = '0;
        for (int c = 0; c < NCH; c++) begin
            if (ch_idx == 3'(c)) sel_ch = bank[c];
        end
    end

    always_comb begin
        rd_mux = '0;
        case (area)
            AREA_GLOBAL: begin
                case (gword)
                    GW_ANY:     rd_mux[NCH-1:0] = tc_masked | err_masked;
                    GW_TC:      rd_mux[NCH-1:0] = tc_masked;
                    GW_ERR:     rd_mux[NCH-1:0] = err_masked;
                    GW_RAW_TC:  rd_mux[NCH-1:0] = tc_raw;
                    GW_RAW_ERR: rd_mux[NCH-1:0] = err_raw;
                    GW_ENABLED: rd_mux[NCH-1:0] = ena_map;
                    GW_CONF:    rd_mux = conf_q;
                    GW_SYNC:    rd_mux = sync_q;
                    default:    rd_mux = '0;
                endcase
            end
            AREA_CHAN: begin
                if ({1'b0, ch_idx} < NCH_W) begin
                    case (cword)
                        CW_SRC:  rd_mux = sel_ch.src;
                        CW_DST:  rd_mux = sel_ch.dst;
                        CW_LLI:  rd_mux = sel_ch.lli;
                        CW_CTL:  rd_mux = sel_ch.ctl;
                        CW_CFG:  rd_mux = sel_ch.cfg;
                        default: rd_mux = '0;
                    endcase
                end
            end
            AREA_ID:  rd_mux[7:0] = id_byte(bus_addr[4:2], WIDE);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (rd_acc) bus_rdata <= rd_mux;
    end

    // R12: read data only moves on a read strobe
    a_r12_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !rd_acc |=> $stable(bus_rdata));

    // R9: configuration word only changes through its own write
    a_r9_conf_write_only: assert property (@(posedge clk) disable iff (rst)
        !(wr_acc && area == AREA_GLOBAL && gword == GW_CONF) |=> $stable(conf_q));

endmodule

// File: tb/dmac_regfile_tb_top.sv
`timescale 1ns/1ps
module dmac_regfile_tb_top;

    localparam int NCH = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    tc_set = '0;
    logic [NCH-1:0]    err_set = '0;
    logic [32*NCH-1:0] ch_src_o, ch_dst_o, ch_lli_o, ch_ctl_o, ch_cfg_o;
    logic [31:0]       glob_cfg_o, glob_sync_o;
    logic              irq_tc, irq_err, irq_any;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    dmac_regfile #(.NCH(NCH)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tc_set(tc_set), .err_set(err_set),
        .ch_src_o(ch_src_o), .ch_dst_o(ch_dst_o), .ch_lli_o(ch_lli_o),
        .ch_ctl_o(ch_ctl_o), .ch_cfg_o(ch_cfg_o),
        .glob_cfg_o(glob_cfg_o), .glob_sync_o(glob_sync_o),
        .irq_tc(irq_tc), .irq_err(irq_err), .irq_any(irq_any)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [NCH-1:0] t, input logic [NCH-1:0] e);
        @(negedge clk);
        tc_set = t; err_set = e;
        @(negedge clk);
        tc_set = '0; err_set = '0;
    endtask

    function automatic logic [31:0] pat(input int c, input int w);
        return 32'h1357_0000 ^ (32'(c) << 12) ^ (32'(w) << 8) ^ 32'(c * 37 + w * 11);
    endfunction

    function automatic logic [11:0] chan_addr(input int c, input int w);
        return 12'h100 + 12'(c * 32 + w * 4);
    endfunction

    function automatic logic [7:0] exp_id(input int i);
        case (i)
            0: return (NCH == 8) ? 8'h80 : 8'h81;
            1: return 8'h10;
            2: return 8'h04;
            3: return 8'h0A;
            4: return 8'h0D;
            5: return 8'hF0;
            6: return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state at the ports and through reads
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 irq", {29'h0, irq_tc, irq_err, irq_any}, 32'h0);
        check("R1 ch_cfg port", ch_cfg_o[31:0] | ch_cfg_o[63:32], 32'h0);
        check("R1 glob ports", glob_cfg_o | glob_sync_o, 32'h0);
        for (int w = 0; w < 14; w++) begin
            bus_read(12'(w * 4), rd);
            check("R1 global word", rd, 32'h0);
        end
        for (int c = 0; c < NCH; c++)
            for (int w = 0; w < 5; w++) begin
                bus_read(chan_addr(c, w), rd);
                check("R1 channel word", rd, 32'h0);
            end

        // R2 R3: write every index/word pair, read all back
        for (int c = 0; c < 8; c++)
            for (int w = 0; w < 8; w++)
                bus_write(chan_addr(c, w), pat(c, w));
        for (int c = 0; c < 8; c++)
            for (int w = 0; w < 8; w++) begin
                bus_read(chan_addr(c, w), rd);
                if (c >= NCH)      check("R3 bad index reads zero", rd, 32'h0);
                else if (w >= 5)   check("R2 spare word reads zero", rd, 32'h0);
                else               check("R2 channel word readback", rd, pat(c, w));
            end
        // R13: engine-side buses
        for (int c = 0; c < NCH; c++) begin
            check("R13 src bus", ch_src_o[32*c +: 32], pat(c, 0));
            check("R13 dst bus", ch_dst_o[32*c +: 32], pat(c, 1));
            check("R13 lli bus", ch_lli_o[32*c +: 32], pat(c, 2));
            check("R13 ctl bus", ch_ctl_o[32*c +: 32], pat(c, 3));
            check("R13 cfg bus", ch_cfg_o[32*c +: 32], pat(c, 4));
        end

        // R4 R5 R6 R7 R8: masks x raw patterns
        for (int m = 0; m < 16; m++) begin
            logic [NCH-1:0] tm, em, en;
            tm = m[1:0];
            em = m[3:2];
            en = tm ^ em;
            for (int c = 0; c < NCH; c++)
                bus_write(chan_addr(c, 4), (32'(tm[c]) << 15) | (32'(em[c]) << 14) | 32'(en[c]));
            for (int r = 0; r < 16; r++) begin
                logic [NCH-1:0] rt, re, mt, me;
                rt = r[1:0];
                re = r[3:2];
                mt = rt & tm;
                me = re & em;
                bus_write(12'h008, 32'hFFFF_FFFF);
                bus_write(12'h010, 32'hFFFF_FFFF);
                check("R5 tc clear all", {31'h0, irq_tc}, 32'h0);
                pulse(rt, re);
                check("R7 irq_tc", {31'h0, irq_tc}, {31'h0, |mt});
                check("R7 irq_err", {31'h0, irq_err}, {31'h0, |me});
                check("R7 irq_any", {31'h0, irq_any}, {31'h0, (|mt) | (|me)});
                bus_read(12'h000, rd); check("R6 combined status", rd, 32'(mt | me));
                bus_read(12'h004, rd); check("R6 masked tc", rd, 32'(mt));
                bus_read(12'h00C, rd); check("R6 masked err", rd, 32'(me));
                bus_read(12'h014, rd); check("R4 raw tc", rd, 32'(rt));
                bus_read(12'h018, rd); check("R4 raw err", rd, 32'(re));
                bus_read(12'h01C, rd); check("R8 enabled bitmap", rd, 32'(en));
            end
        end

        // unmask everything for the directed cases
        for (int c = 0; c < NCH; c++)
            bus_write(chan_addr(c, 4), 32'h0000_C000);

        // R5: partial clears
        pulse(2'b11, 2'b11);
        bus_write(12'h008, 32'h0000_0002);
        bus_read(12'h014, rd); check("R5 partial tc clear", rd, 32'h1);
        bus_write(12'h010, 32'h0000_0001);
        bus_read(12'h018, rd); check("R5 partial err clear", rd, 32'h2);
        bus_write(12'h010, 32'h0000_0002);
        check("R7 irq_err low after clear", {31'h0, irq_err}, 32'h0);
        check("R7 irq_any tc only", {31'h0, irq_any}, 32'h1);

        // R4: set wins over a simultaneous clear
        bus_write(12'h008, 32'hFFFF_FFFF);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h008; bus_wdata = 32'h3;
        tc_set = 2'b10;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tc_set = '0;
        bus_read(12'h014, rd); check("R4 set beats clear", rd, 32'h2);

        // R9: global configuration and sync
        bus_write(12'h030, 32'hA5C3_0F01);
        bus_write(12'h034, 32'h5A3C_F0FE);
        bus_read(12'h030, rd); check("R9 conf readback", rd, 32'hA5C3_0F01);
        bus_read(12'h034, rd); check("R9 sync readback", rd, 32'h5A3C_F0FE);
        check("R9 conf port", glob_cfg_o, 32'hA5C3_0F01);
        check("R9 sync port", glob_sync_o, 32'h5A3C_F0FE);

        // R10: software request words
        pulse(2'b01, 2'b10);
        for (int w = 8; w < 12; w++)
            bus_write(12'(w * 4), 32'hFFFF_FFFF);
        for (int w = 8; w < 12; w++) begin
            bus_read(12'(w * 4), rd);
            check("R10 soft word reads zero", rd, 32'h0);
        end
        bus_read(12'h014, rd); check("R10 raw tc untouched", rd, 32'h3);
        bus_read(12'h018, rd); check("R10 raw err untouched", rd, 32'h2);
        check("R10 conf untouched", glob_cfg_o, 32'hA5C3_0F01);
        check("R10 sync untouched", glob_sync_o, 32'h5A3C_F0FE);

        // R11: identification area
        for (int i = 0; i < 8; i++) begin
            bus_read(12'hFE0 + 12'(i * 4), rd);
            check("R11 id byte", rd, {24'h0, exp_id(i)});
        end
        bus_read(12'h800, rd); check("R11 hole reads zero", rd, 32'h0);

        // R12: read data holds across idle and write cycles
        bus_read(12'h034, held);
        repeat (3) @(negedge clk);
        check("R12 hold idle", bus_rdata, held);
        bus_write(12'h034, 32'h0000_1111);
        check("R12 hold on write", bus_rdata, held);
        check("R12 write effective", glob_sync_o, 32'h0000_1111);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule